// File: doc/BRIEF.md
# Single-Precision Significand Rounder

This combinational block takes a wide significand and rounds it to a 24-bit precision. The significand is 53 bits wide, carries its leading integer bit explicitly, and its bits are numbered MSB-first. The other inputs are a sign, a 12-bit two's-complement exponent, and three extra low-order bits from outside that sit below the significand. A 2-bit mode selects one of four rounding directions. The block decides whether to add one at the last kept position and performs that add with carry-out. On carry it renormalises by moving the leading one back to the top and bumping the exponent. It returns the rounded significand with all discarded positions cleared, together with an increment flag and an inexact flag.

A conversion datapath places its operand in the significand and feeds in any bits it shifted out while denormalising. It then takes the rounded result, the adjusted exponent and the two flags in the same cycle.

Top module: `sp_sig_rounder`

## Requirements
- R1: Mode 2'b00 (nearest, ties to even) increments when guard=1 and kept-lsb=1, or when guard=1, kept-lsb=0 and round or sticky is 1. With MSB-first numbering, kept-lsb is significand bit 23 (vector index 29), guard is bit 24 (index 28) and round is bit 25 (index 27).
- R2: Mode 2'b01 (toward zero) never increments.
- R3: Mode 2'b10 (toward +infinity) increments exactly when sign=0 and any of guard, round or sticky is 1.
- R4: Mode 2'b11 (toward -infinity) increments exactly when sign=1 and any of guard, round or sticky is 1.
- R5: Sticky is the OR of MSB-first significand bits 26..52 (vector indices 26..0) and the three external low bits.
- R6: Without carry-out, the top 24 output bits equal the top 24 input bits plus the increment, and the exponent passes through unchanged.
- R7: When the 25-bit add carries out, the top 24 output bits become a one followed by the upper 23 sum bits, and the exponent increases by one, wrapping within 12 bits.
- R8: Output significand bits 24..52 (vector indices 28..0) are always zero.
- R9: The inexact flag is the OR of guard, round and sticky.
- R10: The increment flag reports the rounding decision. With guard, round and sticky all 0, it is 0 and the top 24 bits pass through exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sign_i | input | 1 | Operand sign, 1 = negative |
| exp_i | input | 12 | Two's-complement exponent |
| sig_i | input | 53 | Significand; index 52 is MSB-first bit 0 |
| ext_g_i | input | 1 | External low bit folded into sticky |
| ext_r_i | input | 1 | External low bit folded into sticky |
| ext_x_i | input | 1 | External low bit folded into sticky |
| mode_i | input | 2 | Rounding direction: 00 nearest, 01 zero, 10 +inf, 11 -inf |
| sig_o | output | 53 | Rounded significand, low 29 bits zero |
| exp_o | output | 12 | Exponent after renormalisation |
| inc_o | output | 1 | Increment was applied |
| inexact_o | output | 1 | Discarded bits were non-zero |

## Verification
The embedded assertions evaluate on every input change. They cover the following:
- the toward-zero mode never increments;
- an exact input never increments;
- an increment always comes with inexact set;
- a carry always leaves a leading one and a bumped exponent, and no carry leaves the exponent alone.

The tie-to-even choice, the sign dependence of the directed modes and the position of each sticky contributor only show up in the bench's sweep, which compares every output against an arithmetic model. The same holds for the exponent wrap at 12'h7FF.

// File: rtl/rnd_pkg.sv
package rnd_pkg;
   typedef enum logic [1:0] {
      RM_NEAR = 2'b00,
      RM_ZERO = 2'b01,
      RM_UP   = 2'b10,
      RM_DOWN = 2'b11
   } rnd_mode_e;

   typedef struct packed {
      logic lsb;
      logic guard;
      logic round;
      logic sticky;
   } rnd_bits_t;
endpackage

// File: rtl/rnd_tap.sv
module rnd_tap
   import rnd_pkg::*;
#(
   parameter int SIG_W  = 53,
   parameter int KEEP_W = 24
) (
   input  logic [SIG_W-1:0] sig_i,
   input  logic             ext_g_i,
   input  logic             ext_r_i,
   input  logic             ext_x_i,
   output rnd_bits_t        bits_o
);
   localparam int LSB_IDX = SIG_W - KEEP_W;
   localparam int GRD_IDX = LSB_IDX - 1;
   localparam int RND_IDX = LSB_IDX - 2;
   localparam int TAIL_W  = RND_IDX;

   logic tail_or;

   generate
      if (KEEP_W < 1 || KEEP_W + 2 > SIG_W) begin : g_bad_cfg
         $error("rnd_tap: KEEP_W must leave room for guard and round bits");
      end
      if (TAIL_W > 0) begin : g_tail
         assign tail_or = |sig_i[TAIL_W-1:0];
      end else begin : g_no_tail
         assign tail_or = 1'b0;
      end
   endgenerate

   always_comb begin
      bits_o.lsb    = sig_i[LSB_IDX];
      bits_o.guard  = sig_i[GRD_IDX];
      bits_o.round  = sig_i[RND_IDX];
      bits_o.sticky = tail_or | ext_g_i | ext_r_i | ext_x_i;
   end
endmodule

// File: rtl/rnd_decide.sv
module rnd_decide
   import rnd_pkg::*;
(
   input  logic      sign_i,
   input  logic [1:0] mode_i,
   input  rnd_bits_t bits_i,
   output logic      inc_o,
   output logic      inexact_o
);
   rnd_mode_e mode;
   logic      lost;

   always_comb begin
      mode = rnd_mode_e'(mode_i);
      lost = bits_i.guard | bits_i.round | bits_i.sticky;
      unique case (mode)
         RM_NEAR: inc_o = bits_i.guard & (bits_i.lsb | bits_i.round | bits_i.sticky);
         RM_ZERO: inc_o = 1'b0;
         RM_UP:   inc_o = ~sign_i & lost;
         RM_DOWN: inc_o = sign_i & lost;
         default: inc_o = 1'b0;
      endcase
      inexact_o = lost;
   end

   // checks tied to R2 and R10
   always_comb begin
      if (mode_i == 2'b01) begin
         p_rtz_hold_r2: assert (!inc_o) else $error("toward-zero incremented");
      end
      if (!(bits_i.guard || bits_i.round || bits_i.sticky)) begin
         p_exact_no_inc_r10: assert (!inc_o) else $error("exact value incremented");
      end
   end
endmodule

// File: rtl/rnd_incr.sv
module rnd_incr #(
   parameter int KEEP_W = 24,
   parameter int EXP_W  = 12
) (
   input  logic [KEEP_W-1:0] top_i,
   input  logic              inc_i,
   input  logic [EXP_W-1:0]  exp_i,
   output logic [KEEP_W-1:0] top_o,
   output logic [EXP_W-1:0]  exp_o,
   output logic              carry_o
);
   localparam int SUM_W = KEEP_W + 1;

   logic [SUM_W-1:0] sum;

   generate
      if (EXP_W < 2) begin : g_bad_exp
         $error("rnd_incr: EXP_W too small");
      end
   endgenerate

   always_comb begin
      sum     = {1'b0, top_i} + SUM_W'(inc_i);
      carry_o = sum[SUM_W-1];
      if (carry_o) begin
         top_o = {1'b1, sum[KEEP_W-1:1]};
         exp_o = exp_i + EXP_W'(1);
      end else begin
         top_o = sum[KEEP_W-1:0];
         exp_o = exp_i;
      end
   end

   // checks tied to R6 and R7
   always_comb begin
      if (carry_o) begin
         p_carry_lead_r7: assert (top_o[KEEP_W-1] && exp_o == EXP_W'(exp_i + EXP_W'(1)))
            else $error("carry without renormalisation");
      end else begin
         p_nocarry_exp_r6: assert (exp_o == exp_i) else $error("exponent moved without carry");
      end
   end
endmodule

// File: rtl/sp_sig_rounder.sv
module sp_sig_rounder
   import rnd_pkg::*;
#(
   parameter int SIG_W  = 53,
   parameter int KEEP_W = 24,
   parameter int EXP_W  = 12
) (
   input  logic             sign_i,
   input  logic [EXP_W-1:0] exp_i,
   input  logic [SIG_W-1:0] sig_i,
   input  logic             ext_g_i,
   input  logic             ext_r_i,
   input  logic             ext_x_i,
   input  logic [1:0]       mode_i,
   output logic [SIG_W-1:0] sig_o,
   output logic [EXP_W-1:0] exp_o,
   output logic             inc_o,
   output logic             inexact_o
);
   localparam int LOW_W = SIG_W - KEEP_W;

   rnd_bits_t         bits;
   logic [KEEP_W-1:0] top_rnd;
   logic              carry;

   rnd_tap #(.SIG_W(SIG_W), .KEEP_W(KEEP_W)) u_tap (
      .sig_i   (sig_i),
      .ext_g_i (ext_g_i),
      .ext_r_i (ext_r_i),
      .ext_x_i (ext_x_i),
      .bits_o  (bits)
   );

   rnd_decide u_decide (
      .sign_i    (sign_i),
      .mode_i    (mode_i),
      .bits_i    (bits),
      .inc_o     (inc_o),
      .inexact_o (inexact_o)
   );

   rnd_incr #(.KEEP_W(KEEP_W), .EXP_W(EXP_W)) u_incr (
      .top_i   (sig_i[SIG_W-1:LOW_W]),
      .inc_i   (inc_o),
      .exp_i   (exp_i),
      .top_o   (top_rnd),
      .exp_o   (exp_o),
      .carry_o (carry)
   );

   assign sig_o = {top_rnd, {LOW_W{1'b0}}};

   // R9: an increment is only possible when bits were lost
   always_comb begin
      if (inc_o) begin
         p_inc_needs_inexact_r9: assert (inexact_o) else $error("increment on exact value");
      end
      if (carry) begin
         p_carry_from_inc_r7: assert (inc_o) else $error("carry without increment");
      end
   end
endmodule

// File: tb/sp_sig_rounder_test.sv
module sp_sig_rounder_test;
   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic        sign_i;
   logic [11:0] exp_i;
   logic [52:0] sig_i;
   logic        ext_g_i, ext_r_i, ext_x_i;
   logic [1:0]  mode_i;
   logic [52:0] sig_o;
   logic [11:0] exp_o;
   logic        inc_o, inexact_o;

   int n_chk = 0;
   int n_bad = 0;
   logic [31:0] seed = 32'h1234_5678;

   sp_sig_rounder uut (
      .sign_i(sign_i), .exp_i(exp_i), .sig_i(sig_i),
      .ext_g_i(ext_g_i), .ext_r_i(ext_r_i), .ext_x_i(ext_x_i),
      .mode_i(mode_i), .sig_o(sig_o), .exp_o(exp_o),
      .inc_o(inc_o), .inexact_o(inexact_o)
   );

   function automatic logic [31:0] next_rand(logic [31:0] s);
      return s * 32'd1103515245 + 32'd12345;
   endfunction

   task automatic cmp(string tag, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // drive one vector, wait, compare with the arithmetic model
   task automatic run_vec(logic s, logic [1:0] m, logic [11:0] e, logic [52:0] sg,
                          logic eg, logic er, logic ex);
      logic [23:0] top, top_e;
      logic        g, r, st, inc;
      logic [24:0] sum;
      logic [11:0] e_e;
      string       tag_inc;
      @(posedge clk);
      sign_i = s; mode_i = m; exp_i = e; sig_i = sg;
      ext_g_i = eg; ext_r_i = er; ext_x_i = ex;
      @(negedge clk);
      top = sg[52:29];
      g   = sg[28];
      r   = sg[27];
      st  = (sg[26:0] != 27'd0) | eg | er | ex;
      case (m)
         2'b00: begin inc = g & (top[0] | r | st); tag_inc = "R1"; end
         2'b01: begin inc = 1'b0;                  tag_inc = "R2"; end
         2'b10: begin inc = !s & (g | r | st);     tag_inc = "R3"; end
         default: begin inc = s & (g | r | st);    tag_inc = "R4"; end
      endcase
      sum = {1'b0, top} + 25'(inc);
      if (sum[24]) begin
         top_e = {1'b1, sum[23:1]};
         e_e   = e + 12'd1;
         cmp("R7 top", 64'(sig_o[52:29]), 64'(top_e));
         cmp("R7 exp", 64'(exp_o), 64'(e_e));
      end else begin
         top_e = sum[23:0];
         cmp("R6 top", 64'(sig_o[52:29]), 64'(top_e));
         cmp("R6 exp", 64'(exp_o), 64'(e));
      end
      cmp(tag_inc, 64'(inc_o), 64'(inc));
      cmp("R8 low", 64'(sig_o[28:0]), 64'd0);
      if (!g && !r && st) cmp("R5 sticky", 64'(inexact_o), 64'd1);
      else cmp("R9 inexact", 64'(inexact_o), 64'(g | r | st));
      if (!(g | r | st)) cmp("R10 exact", 64'(inc_o), 64'd0);
   endtask

   initial begin
      sign_i = 0; mode_i = 0; exp_i = 0; sig_i = 0;
      ext_g_i = 0; ext_r_i = 0; ext_x_i = 0;
      @(negedge clk);
      // R10: all-zero input gives an all-zero result
      cmp("R10 zero sig", 64'(sig_o), 64'd0);
      cmp("R10 zero inc", 64'(inc_o), 64'd0);

      // sweep sign, mode, lsb, guard, round and each sticky source
      for (int s = 0; s < 2; s++)
         for (int m = 0; m < 4; m++)
            for (int lgr = 0; lgr < 8; lgr++)
               for (int src = 0; src < 6; src++) begin
                  logic [52:0] sg;
                  seed = next_rand(seed);
                  sg = {seed[22:0], 30'd0};
                  sg[29] = lgr[2];
                  sg[28] = lgr[1];
                  sg[27] = lgr[0];
                  if (src == 1) sg[0] = 1'b1;
                  if (src == 2) sg[26] = 1'b1;
                  run_vec(s[0], m[1:0], seed[31:20], sg,
                          src == 3, src == 4, src == 5);
               end

      // R7: carry cases, including exponent wrap at 12'h7FF and 12'hFFF
      for (int m = 0; m < 4; m++)
         for (int s = 0; s < 2; s++) begin
            run_vec(s[0], m[1:0], 12'h7FF, {24'hFFFFFF, 29'h1000_0000}, 0, 0, 0);
            run_vec(s[0], m[1:0], 12'hFFF, {24'hFFFFFF, 29'h0000_0001}, 0, 0, 0);
            run_vec(s[0], m[1:0], 12'h07F, {24'hFFFFFF, 29'h0}, 0, 0, 1);
         end

      // random mix
      for (int i = 0; i < 400; i++) begin
         logic [52:0] sg;
         seed = next_rand(seed);
         sg[52:21] = seed;
         seed = next_rand(seed);
         sg[20:0] = seed[20:0];
         if (seed[21]) sg[26:0] = 27'd0;
         run_vec(seed[22], seed[24:23], seed[31:20], sg, seed[25] & seed[26], 0, 0);
      end

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule